// File: doc/BRIEF.md
# Flush-Aware Input/Output Handshake Wrapper

This block surrounds a small compute core with request/acknowledge handshakes. It has a parameterised number of input lanes and one output lane. Every input word carries one extra bit above its data, and that bit marks a flush token. The wrapper keeps one acknowledge register and one flush register for each input lane, and one request register for the output lane. From these registers it derives a status for each lane: empty, full or draining. The core uses two actions: it drains an input and it fills the output.

The stand-in core adds the data words of all input lanes, wrapping modulo 2^W. It fires only when every input lane holds an ordinary word and the output lane is empty. Flush tokens are handled for all lanes together. Nothing happens until every lane has a word waiting. If every waiting word is a token, all of them are acknowledged together. If only some are tokens, the ordinary words on the other lanes are discarded, and the tokens wait for the remaining lanes to catch up.

Top module: `dock_wrapper`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `in_ack` becomes 1 and `out_req` becomes 0 (synchronous, active-high reset).
- R2: Lane i's word is `in_word[i*(W+1) +: W+1]`. Bit W of the lane is the flush flag, and the core sees the lane's request only when `in_req[i]` is high and the flag is 0.
- R3: When every lane shows an unflagged word with `in_ack` low and the output is empty (`out_req` and `out_ack` both low), the next edge raises every `in_ack` bit and `out_req`. At the same edge `out_word` takes the sum of all lane data words modulo 2^W.
- R4: An input lane's acknowledge drops at the first edge at which its raw request is low.
- R5: While `out_req` is high and `out_ack` is low, `out_req` stays high and `out_word` holds its value. `out_req` drops at the edge after `out_ack` is seen high.
- R6: While the output lane is not empty, the core does not fire. Waiting input words stay unacknowledged.
- R7: When every lane has its raw request high, its acknowledge low, and its flush flag set, the next edge raises every `in_ack` bit and produces no output.
- R8: When every lane is waiting and only some carry the flag, the next edge raises `in_ack` only on the unflagged lanes, which discards their words. It produces no output.
- R9: A lane's acknowledge from a flush drops at the edge after its raw request goes low.
- R10: While any lane has no raw request, nothing is acknowledged and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | N | Raw request for each input lane |
| in_word | input | N*(W+1) | Packed input lanes, each with a flush flag at bit W |
| in_ack | output | N | Acknowledge for each input lane (drain or flush) |
| out_req | output | 1 | Output lane request |
| out_word | output | W | Output data word |
| out_ack | input | 1 | Output lane acknowledge |

## Verification
A stuck acknowledge or flush register shows on `in_ack` within one edge of the producer lowering its request, because such a register would leave the acknowledge high when it should drop. A wrong token decision shows on `in_ack` and `out_req` at the first edge after every lane is waiting. A wrong mask shows on the same edge, either as a spurious output or as the wrong set of lanes acknowledged. A corrupted output register appears on `out_word` while the request is held, and an early release appears as `out_req` dropping before `out_ack`.

// File: rtl/dock_pkg.sv
package dock_pkg;

    typedef enum logic [1:0] {
        HS_EMPTY    = 2'd0,
        HS_FULL     = 2'd1,
        HS_RETIRING = 2'd2,
        HS_DRAINING = 2'd3
    } hs_state_e;

    // Classify a lane from its request and acknowledge levels
    function automatic hs_state_e hs_classify(input logic req, input logic ack);
        case ({req, ack})
            2'b00:   return HS_EMPTY;
            2'b10:   return HS_FULL;
            2'b11:   return HS_DRAINING;
            default: return HS_RETIRING;
        endcase
    endfunction

endpackage

// File: rtl/dock_in_port.sv
module dock_in_port
    import dock_pkg::*;
#(
    parameter int W = 37
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_raw,
    input  logic [W:0]   word,
    input  logic         drain,
    input  logic         flush_set,
    output logic         ack_ext,
    output logic         ack_reg,
    output logic         flag,
    output logic [W-1:0] data,
    output logic         full
);

    logic eff_req;
    logic flush_q;

    assign flag    = word[W];
    assign data    = word[W-1:0];
    assign eff_req = req_raw & ~flag;
    assign full    = (hs_classify(eff_req, ack_reg) == HS_FULL);
    assign ack_ext = ack_reg | flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_reg <= 1'b1;
            flush_q <= 1'b0;
        end else begin
            if (drain)
                ack_reg <= 1'b1;
            else if (!eff_req && ack_reg)
                ack_reg <= 1'b0;
            if (!req_raw)
                flush_q <= 1'b0;
            else if (flush_set)
                flush_q <= 1'b1;
        end
    end

    // R4 / R9: a lowered raw request clears the external acknowledge next edge
    p_ack_release_r4: assert property (@(posedge clk) disable iff (rst)
        !req_raw |=> !ack_ext);

    // R2: the drain register only rises for an unflagged, requested word
    p_drain_unflagged_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_reg) |-> $past(req_raw && !word[W]));

endmodule

// File: rtl/dock_flush_ctrl.sv
module dock_flush_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_raw,
    input  logic [N-1:0] ack_reg,
    input  logic [N-1:0] flag,
    output logic [N-1:0] flush_set
);

    logic all_waiting;

    assign all_waiting = &(req_raw & ~ack_reg);

    always_comb begin
        flush_set = '0;
        if (all_waiting) begin
            if (&flag)
                flush_set = '1;
            else if (|flag)
                flush_set = ~flag;
        end
    end

    // R10: no flush decision unless every lane is requesting
    p_flush_needs_all_r10: assert property (@(posedge clk) disable iff (rst)
        (|flush_set) |-> (&req_raw));

    // R8: a partial flush never touches a flagged lane
    p_partial_spares_flagged_r8: assert property (@(posedge clk) disable iff (rst)
        (|flush_set && !(&flag)) |-> ((flush_set & flag) == '0));

endmodule

// File: rtl/dock_out_port.sv
module dock_out_port
    import dock_pkg::*;
#(
    parameter int W = 37
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fill,
    input  logic [W-1:0] fill_data,
    input  logic         ack,
    output logic         req,
    output logic [W-1:0] data,
    output logic         empty
);

    assign empty = (hs_classify(req, ack) == HS_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            data <= '0;
        end else begin
            if (fill) begin
                req  <= 1'b1;
                data <= fill_data;
            end else if (req && ack) begin
                req <= 1'b0;
            end
        end
    end

    // R5: request and data hold until acknowledged
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(data)));

    // R5: request released after acknowledge
    p_out_release_r5: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

endmodule

// File: rtl/dock_wrapper.sv
module dock_wrapper
    import dock_pkg::*;
#(
    parameter int W = 37,
    parameter int N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     in_req,
    input  logic [N*(W+1)-1:0] in_word,
    output logic [N-1:0]     in_ack,
    output logic             out_req,
    output logic [W-1:0]     out_word,
    input  logic             out_ack
);

    localparam int LW = W + 1;

    logic [N-1:0]   lane_full;
    logic [N-1:0]   lane_ack_reg;
    logic [N-1:0]   lane_flag;
    logic [N-1:0]   lane_flush;
    logic [W-1:0]   lane_data [N];
    logic [W-1:0]   sum;
    logic           out_empty;
    logic           fire;

    for (genvar i = 0; i < N; i++) begin : g_lane
        dock_in_port #(.W(W)) u_in (
            .clk       (clk),
            .rst       (rst),
            .req_raw   (in_req[i]),
            .word      (in_word[i*LW +: LW]),
            .drain     (fire),
            .flush_set (lane_flush[i]),
            .ack_ext   (in_ack[i]),
            .ack_reg   (lane_ack_reg[i]),
            .flag      (lane_flag[i]),
            .data      (lane_data[i]),
            .full      (lane_full[i])
        );
    end

    dock_flush_ctrl #(.N(N)) u_flush (
        .clk       (clk),
        .rst       (rst),
        .req_raw   (in_req),
        .ack_reg   (lane_ack_reg),
        .flag      (lane_flag),
        .flush_set (lane_flush)
    );

    // Stand-in core: modular sum of all lanes
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++)
            sum = sum + lane_data[i];
    end

    assign fire = (&lane_full) && out_empty;

    dock_out_port #(.W(W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .fill      (fire),
        .fill_data (sum),
        .ack       (out_ack),
        .req       (out_req),
        .data      (out_word),
        .empty     (out_empty)
    );

    // R6: output only starts from an empty lane
    p_fill_from_empty_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(out_req) |-> $past(!out_req && !out_ack));

    // R7: a flush round never produces an output
    p_flush_no_output_r7: assert property (@(posedge clk) disable iff (rst)
        (|lane_flush) |=> !$rose(out_req));

endmodule

// File: tb/dock_wrapper_tb.sv
module dock_wrapper_tb;

    localparam int W  = 37;
    localparam int N  = 2;
    localparam int LW = W + 1;

    logic             clk = 1'b0;
    logic             rst;
    logic [N-1:0]     in_req;
    logic [N*LW-1:0]  in_word;
    logic [N-1:0]     in_ack;
    logic             out_req;
    logic [W-1:0]     out_word;
    logic             out_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dock_wrapper #(.W(W), .N(N)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_req   (in_req),
        .in_word  (in_word),
        .in_ack   (in_ack),
        .out_req  (out_req),
        .out_word (out_word),
        .out_ack  (out_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_lane(input int i, input logic flg, input logic [W-1:0] d);
        in_word[i*LW +: LW] = {flg, d};
    endtask

    function automatic logic [W-1:0] wsum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[W-1:0];
    endfunction

    task automatic t_reset();
        rst = 1; in_req = '0; in_word = '0; out_ack = 0;
        cyc(3);
        chk("R1 in_ack", {62'd0, in_ack}, 64'h3);
        chk("R1 out_req", {63'd0, out_req}, 64'h0);
        rst = 0;
        cyc(1);
        chk("R4 ack drop after reset", {62'd0, in_ack}, 64'h0);
    endtask

    // Present two plain words, check consume and output, then complete handshakes
    task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
        set_lane(0, 0, a); set_lane(1, 0, b); in_req = 2'b11;
        cyc(1);
        chk("R3 in_ack", {62'd0, in_ack}, 64'h3);
        chk("R3 out_req", {63'd0, out_req}, 64'h1);
        chk("R3 out_word", {27'd0, out_word}, {27'd0, wsum(a, b)});
        in_req = 2'b00;
        cyc(1);
        chk("R4 in_ack drop", {62'd0, in_ack}, 64'h0);
        cyc(3);
        chk("R5 hold req", {63'd0, out_req}, 64'h1);
        chk("R5 hold word", {27'd0, out_word}, {27'd0, wsum(a, b)});
        out_ack = 1;
        cyc(1);
        chk("R5 release", {63'd0, out_req}, 64'h0);
        out_ack = 0;
        cyc(1);
    endtask

    task automatic t_backpressure();
        logic [W-1:0] first;
        first = wsum(37'd5, 37'd6);
        set_lane(0, 0, 37'd5); set_lane(1, 0, 37'd6); in_req = 2'b11;
        cyc(1);
        in_req = 2'b00;
        cyc(1);
        set_lane(0, 0, 37'd100); set_lane(1, 0, 37'd23); in_req = 2'b11;
        cyc(3);
        chk("R6 inputs held off", {62'd0, in_ack}, 64'h0);
        chk("R6 word kept", {27'd0, out_word}, {27'd0, first});
        out_ack = 1;
        cyc(1);
        chk("R5 release under backpressure", {63'd0, out_req}, 64'h0);
        chk("R6 still waiting", {62'd0, in_ack}, 64'h0);
        out_ack = 0;
        cyc(1);
        chk("R6 fires once empty", {62'd0, in_ack}, 64'h3);
        chk("R6 new word", {27'd0, out_word}, 64'd123);
        in_req = 2'b00;
        out_ack = 1;
        cyc(1);
        out_ack = 0;
        cyc(1);
    endtask

    task automatic t_flush_all();
        set_lane(0, 1, 37'd9); set_lane(1, 1, 37'd9); in_req = 2'b11;
        cyc(1);
        chk("R7 all acked", {62'd0, in_ack}, 64'h3);
        chk("R7 no output", {63'd0, out_req}, 64'h0);
        cyc(1);
        chk("R2 R7 flush ack held while req high", {62'd0, in_ack}, 64'h3);
        in_req = 2'b00;
        cyc(1);
        chk("R9 flush ack drop", {62'd0, in_ack}, 64'h0);
        chk("R7 still no output", {63'd0, out_req}, 64'h0);
    endtask

    task automatic t_flush_partial();
        set_lane(0, 1, 37'd1); set_lane(1, 0, 37'd77); in_req = 2'b11;
        cyc(1);
        chk("R8 only unflagged acked", {62'd0, in_ack}, 64'h2);
        chk("R8 no output", {63'd0, out_req}, 64'h0);
        in_req = 2'b01;
        cyc(1);
        chk("R9 discard ack drop", {62'd0, in_ack}, 64'h0);
        set_lane(1, 1, 37'd0); in_req = 2'b11;
        cyc(1);
        chk("R8 token pair flushed", {62'd0, in_ack}, 64'h3);
        in_req = 2'b00;
        cyc(1);
        chk("R9 pair ack drop", {62'd0, in_ack}, 64'h0);
    endtask

    task automatic t_single();
        set_lane(0, 0, 37'd4); set_lane(1, 1, 37'd0); in_req = 2'b01;
        cyc(3);
        chk("R10 lone lane", {62'd0, in_ack}, 64'h0);
        chk("R10 no output", {63'd0, out_req}, 64'h0);
        set_lane(1, 0, 37'd8); in_req = 2'b11;
        cyc(1);
        chk("R10 fires when complete", {62'd0, in_ack}, 64'h3);
        chk("R10 word", {27'd0, out_word}, 64'd12);
        in_req = 2'b00;
        out_ack = 1;
        cyc(1);
        out_ack = 0;
        cyc(1);
    endtask

    initial begin
        t_reset();
        t_add(37'd10, 37'd20);
        t_add({W{1'b1}}, 37'd2);
        t_backpressure();
        t_flush_all();
        t_flush_partial();
        t_single();
        t_add(37'h12_3456_789A, 37'h0F_0F0F_0F0F);
        done = 1;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule